// File: doc/BRIEF.md
# Display Reset and Enable Controller

This block is the display control section of a 2D graphics display engine. A host-writable control word holds two bits, a hold bit and a run bit. Together they select what drives the 18-bit display data output: a programmable blanking colour, pixel data from frame memory, or all zeros. The block starts the engine in the hold state. While the engine is held it blocks drawing start requests, forces the vertical-blank status low and stalls CPU accesses to frame memory. An external lock input keeps the hold bit set for as long as it is asserted.

Pixel output never begins or ends in the middle of a frame. A committed source register follows the run bit only on a frame-start pulse. Entering the hold state removes pixel data at once. The blanking colour is stored in two host registers: a 2-bit upper part and a 16-bit lower part. All registers are read back on the same port.

Top module: `dispctl_top`

## Requirements
- R1: After synchronous reset the control word reads hold=1, run=0 (bit 4 = hold, bit 3 = run, address 0). Both blanking registers (address 1 upper, address 2 lower) read 0, and the display output is 0.
- R2: A control write that asks for hold=1 and run=1 stores hold=1, run=0. The value hold=1, run=1 is never stored.
- R3: While lock_i is high and the hold bit is 1, a control write with hold=0 leaves the hold bit at 1. The run bit is then stored as 0.
- R4: With hold=0 and the committed source not yet showing pixels, disp_data_o equals {upper[1:0], lower[15:0]} of the blanking registers.
- R5: A write of hold=0, run=1 switches disp_data_o to pix_data_i only after the clock edge at which frame_start_i is high. Clearing run returns the output to the blanking colour only at such an edge.
- R6: While hold=1, draw_req_i does not produce draw_start_o. With hold=0, draw_start_o follows draw_req_i in the same cycle.
- R7: While hold=1, disp_data_o is all zeros and vblank_o is 0, whatever pix_data_i and vblank_i are.
- R8: While hold=1, mem_wait_o equals mem_req_i. With hold=0, mem_wait_o is 0.
- R9: Control bits other than bit 4 and bit 3 read 0, including the reserved bits 2:0. Bits above the register width of the blanking upper part read 0. Address 3 reads 0.
- R10: Writing hold=1 while pixels are shown forces zero output from the next cycle and clears the committed source. Leaving hold with run=0 then shows the blanking colour without waiting for a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | External lock, keeps hold bit from clearing |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| frame_start_i | input | 1 | Single-cycle frame boundary pulse |
| pix_data_i | input | 18 | Pixel data from frame memory |
| draw_req_i | input | 1 | Host drawing start request |
| draw_start_o | output | 1 | Drawing start passed to the draw engine |
| vblank_i | input | 1 | Vertical-blank indication from timing |
| vblank_o | output | 1 | Vertical-blank status flag |
| mem_req_i | input | 1 | CPU frame-memory access request |
| mem_wait_o | output | 1 | Wait to the CPU |
| disp_data_o | output | 18 | Display data output |

## Verification
A register write takes effect at the clock edge where wr_en_i is high. The readback, the output selection and the gating outputs then show the new value from that edge on. The committed pixel source changes only at an edge where frame_start_i is high, so pixel output is checked both one cycle before and one cycle after that pulse. Draw, wait and vblank gating are combinational from the stored hold bit and are checked in the same cycle as their inputs. The bench drives and samples on the falling edge, so each check sees the state after exactly one rising edge. It sweeps every combination of prior state, lock level and requested encoding.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
    localparam int DATA_W   = 18;
    localparam int LO_W     = 16;
    localparam int HI_W     = DATA_W - LO_W;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 2;
    localparam int HOLD_BIT = 4;
    localparam int RUN_BIT  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] A_LO   = 2'd2;

    typedef struct packed {
        logic hold;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_BLANK = 2'd1,
        SRC_PIX   = 2'd2
    } src_e;

    // Resolve a requested control word: lock keeps hold set, hold wins over run.
    function automatic ctrl_t resolve_ctrl(input logic req_hold, input logic req_run,
                                           input logic lock, input logic cur_hold);
        ctrl_t r;
        r.hold = req_hold | (lock & cur_hold);
        r.run  = req_run & ~r.hold;
        return r;
    endfunction
endpackage

// File: rtl/dispctl_regs.sv
module dispctl_regs
    import dispctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lock_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [REG_W-1:0]     wdata_i,
    output logic [REG_W-1:0]     rdata_o,
    output ctrl_t                ctrl_o,
    output logic [DATA_W-1:0]    blank_o
);
    ctrl_t            ctrl_q;
    logic [HI_W-1:0]  hi_q;
    logic [LO_W-1:0]  lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{hold: 1'b1, run: 1'b0};
            hi_q   <= '0;
            lo_q   <= '0;
        end else if (wr_en_i) begin
            case (addr_i)
                A_CTRL: ctrl_q <= resolve_ctrl(wdata_i[HOLD_BIT], wdata_i[RUN_BIT],
                                               lock_i, ctrl_q.hold);
                A_HI:   hi_q   <= wdata_i[HI_W-1:0];
                A_LO:   lo_q   <= wdata_i[LO_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[HOLD_BIT] = ctrl_q.hold;
                rdata_o[RUN_BIT]  = ctrl_q.run;
            end
            A_HI:   rdata_o[HI_W-1:0] = hi_q;
            A_LO:   rdata_o[LO_W-1:0] = lo_q;
            default: rdata_o = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign blank_o = {hi_q, lo_q};

    assert_no_prohibited_R2: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_q.hold && ctrl_q.run));

    assert_lock_keeps_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (lock_i && ctrl_q.hold) |=> ctrl_q.hold);
endmodule

// File: rtl/dispctl_srcsel.sv
module dispctl_srcsel
    import dispctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl_i,
    input  logic  frame_start_i,
    output src_e  src_o
);
    logic pix_q;

    always_ff @(posedge clk) begin
        if (rst || ctrl_i.hold)
            pix_q <= 1'b0;
        else if (frame_start_i)
            pix_q <= ctrl_i.run;
    end

    always_comb begin
        if (ctrl_i.hold)  src_o = SRC_ZERO;
        else if (pix_q)   src_o = SRC_PIX;
        else              src_o = SRC_BLANK;
    end

    assert_commit_on_frame_R5: assert property (@(posedge clk) disable iff (rst)
        (!frame_start_i && !ctrl_i.hold) |=> $stable(pix_q));

    assert_hold_drops_pix_R10: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.hold |=> !pix_q);
endmodule

// File: rtl/dispctl_outpath.sv
module dispctl_outpath
    import dispctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_i,
    input  src_e              src_i,
    input  logic [DATA_W-1:0] blank_i,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              draw_req_i,
    input  logic              vblank_i,
    input  logic              mem_req_i,
    output logic              draw_start_o,
    output logic              vblank_o,
    output logic              mem_wait_o,
    output logic [DATA_W-1:0] disp_o
);
    always_comb begin
        case (src_i)
            SRC_PIX:   disp_o = pix_i;
            SRC_BLANK: disp_o = blank_i;
            default:   disp_o = '0;
        endcase
    end

    assign draw_start_o = draw_req_i & ~ctrl_i.hold;
    assign vblank_o     = vblank_i & ~ctrl_i.hold;
    assign mem_wait_o   = mem_req_i & ctrl_i.hold;

    assert_zero_out_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.hold |-> (disp_o == '0 && !vblank_o));

    assert_no_draw_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.hold |-> !draw_start_o);

    assert_wait_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.hold && mem_req_i) |-> mem_wait_o);
endmodule

// File: rtl/dispctl_top.sv
module dispctl_top
    import dispctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lock_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [REG_W-1:0]     wdata_i,
    output logic [REG_W-1:0]     rdata_o,
    input  logic                 frame_start_i,
    input  logic [DATA_W-1:0]    pix_data_i,
    input  logic                 draw_req_i,
    output logic                 draw_start_o,
    input  logic                 vblank_i,
    output logic                 vblank_o,
    input  logic                 mem_req_i,
    output logic                 mem_wait_o,
    output logic [DATA_W-1:0]    disp_data_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] blank;
    src_e              src;

    dispctl_regs u_regs (
        .clk(clk), .rst(rst), .lock_i(lock_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .ctrl_o(ctrl), .blank_o(blank)
    );

    dispctl_srcsel u_src (
        .clk(clk), .rst(rst), .ctrl_i(ctrl),
        .frame_start_i(frame_start_i), .src_o(src)
    );

    dispctl_outpath u_out (
        .clk(clk), .rst(rst), .ctrl_i(ctrl), .src_i(src),
        .blank_i(blank), .pix_i(pix_data_i), .draw_req_i(draw_req_i),
        .vblank_i(vblank_i), .mem_req_i(mem_req_i),
        .draw_start_o(draw_start_o), .vblank_o(vblank_o),
        .mem_wait_o(mem_wait_o), .disp_o(disp_data_o)
    );
endmodule

// File: tb/dispctl_top_tb_top.sv
module dispctl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock_i = 1'b0, wr_en_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        frame_start_i = 1'b0;
    logic [17:0] pix_data_i = '0;
    logic        draw_req_i = 1'b0, vblank_i = 1'b0, mem_req_i = 1'b0;
    logic        draw_start_o, vblank_o, mem_wait_o;
    logic [17:0] disp_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dispctl_top dut_i (
        .clk(clk), .rst(rst), .lock_i(lock_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .frame_start_i(frame_start_i), .pix_data_i(pix_data_i),
        .draw_req_i(draw_req_i), .draw_start_o(draw_start_o),
        .vblank_i(vblank_i), .vblank_o(vblank_o),
        .mem_req_i(mem_req_i), .mem_wait_o(mem_wait_o),
        .disp_data_o(disp_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr_i = a; #1; d = rdata_o;
    endtask

    task automatic frame();
        @(negedge clk); frame_start_i = 1'b1;
        @(negedge clk); frame_start_i = 1'b0;
    endtask

    function automatic logic [15:0] cw(input logic h, input logic r);
        return (16'(h) << 4) | (16'(r) << 3);
    endfunction

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [17:0] blank;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", d, cw(1, 0));
        rd(2'd1, d); chk("R1 hi", d, 0);
        rd(2'd2, d); chk("R1 lo", d, 0);
        chk("R1 disp", disp_data_o, 0);

        // R9 readback masks
        wr(2'd0, 16'hFFE7 | cw(1, 0));
        rd(2'd0, d); chk("R9 ctrl mask", d, cw(1, 0));
        wr(2'd1, 16'hFFFF); rd(2'd1, d); chk("R9 hi mask", d, 16'h0003);
        rd(2'd3, d); chk("R9 addr3", d, 0);

        // R6 R7 R8 gating in hold
        pix_data_i = 18'h2ABCD; vblank_i = 1; draw_req_i = 1; mem_req_i = 1;
        #1;
        chk("R7 disp zero", disp_data_o, 0);
        chk("R7 vblank", vblank_o, 0);
        chk("R6 draw", draw_start_o, 0);
        chk("R8 wait", mem_wait_o, 1);
        frame();
        chk("R7 disp zero after frame", disp_data_o, 0);

        // R2 R3 sweep of prior state x lock x request
        for (int lk = 0; lk < 2; lk++) begin
            for (int pv = 0; pv < 3; pv++) begin
                for (int rq = 0; rq < 4; rq++) begin
                    logic ph, pr, eh, er;
                    ph = (pv == 2); pr = (pv == 1);
                    lock_i = 1'b0;
                    wr(2'd0, cw(1, 0));
                    wr(2'd0, cw(ph, pr));
                    lock_i = lk[0];
                    wr(2'd0, cw(rq[1], rq[0]));
                    eh = rq[1] | (lk[0] & ph);
                    er = rq[0] & ~eh;
                    rd(2'd0, d);
                    chk(lk ? "R3 locked write" : "R2 write resolve", d, cw(eh, er));
                end
            end
        end
        lock_i = 1'b0;

        // R4 blanking colour, several patterns
        wr(2'd0, cw(0, 0));
        for (int i = 0; i < 4; i++) begin
            logic [17:0] v;
            v = 18'(32'h1357 * (i + 3) + i * 65536);
            wr(2'd1, 16'(v[17:16]));
            wr(2'd2, v[15:0]);
            #1;
            chk("R4 blank out", disp_data_o, v);
        end
        blank = disp_data_o;
        chk("R6 draw pass", draw_start_o, 1);
        chk("R7 vblank pass", vblank_o, 1);
        chk("R8 no wait", mem_wait_o, 0);

        // R5 frame-boundary switch
        wr(2'd0, cw(0, 1));
        chk("R5 before frame", disp_data_o, blank);
        @(negedge clk);
        chk("R5 still before frame", disp_data_o, blank);
        frame();
        for (int i = 0; i < 4; i++) begin
            pix_data_i = 18'(i * 18'h0F0F1 + 5);
            #1;
            chk("R5 pixel out", disp_data_o, pix_data_i);
        end
        wr(2'd0, cw(0, 0));
        chk("R5 stop waits frame", disp_data_o, pix_data_i);
        frame();
        chk("R5 stop after frame", disp_data_o, blank);

        // R10 hold drops pixels immediately
        wr(2'd0, cw(0, 1));
        frame();
        chk("R10 pix shown", disp_data_o, pix_data_i);
        wr(2'd0, cw(1, 0));
        chk("R10 zero at once", disp_data_o, 0);
        wr(2'd0, cw(0, 0));
        chk("R10 blank no frame", disp_data_o, blank);
        wr(2'd0, cw(0, 1));
        chk("R10 no early pix", disp_data_o, blank);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule